// File: doc/BRIEF.md
# Hardwired Four-Step Instruction Sequencer

This block is the control section of a small multicycle 32-bit load/store processor. A free-running 2-bit step counter gives every instruction exactly four clock cycles, from step 0 to step 3. A jump needs only two of them but still gets all four. The counter is decoded into one-hot step lines. The 6-bit opcode of the instruction register is decoded into 64 one-hot lines, and lines for codes the machine does not define stay low.

Combinational logic takes the step lines, the opcode lines, the R-type function field and the register-equality flag. From these it builds a 17-bit control word in every cycle. The word drives the datapath: load enables, multiplexer selects, the ALU operation and the memory strobes. The ALU input and output registers load in every cycle, so the word has no bits for them.

Control word layout, most significant bit first: [16] load IR, [15] load PC, [14] write register file, [13] memory read, [12] memory write, [11:10] PC source, [9] memory address select, [8] write-data select, [7] ALU A select, [6:5] ALU B select, [4:3] destination select, [2:0] ALU operation.

Top module: `hwc_ctrl_unit`

## Requirements
- R1: Reset is synchronous and active low. It forces the step counter to 0, so the word presented during and right after reset is the fetch word. A reset asserted in mid-instruction takes effect at the next clock edge.
- R2: Once out of reset, the step advances 0, 1, 2, 3, 0 on every clock for every opcode, defined or not, so each instruction occupies exactly four cycles.
- R3: Step 0 always produces the fetch word, whatever the inputs: load IR=1, load PC=1, memory read=1, PC source=0, address select=0 (PC), ALU A=0 (PC), ALU B=1 (constant 4), ALU operation=0 (add), and all other fields 0. Load IR is 0 in steps 1 to 3.
- R4: Load PC is 1 only in step 0, and in step 1 for the following: J (opcode 0x02), JAL (0x03), the register jump (opcode 0x00 with function 0x08), BEQ (0x04) when equal=1, and BNE (0x05) when equal=0.
- R5: PC source is 0 (sequential) in steps 0 and 2, 1 (step-1 target) in step 1 and 3 (ALU output) in step 3.
- R6: In steps 1 to 3, address select and ALU A are 1. In step 1, ALU operation is 1 (subtract) and ALU B is 0 (register). For JAL, step 1 also sets register write=1 and destination=2 (link register).
- R7: In step 2, ALU B is 3 (zero-extended immediate) for ANDI 0x0C, ORI 0x0D, XORI 0x0E and LUI 0x0F. It is 2 (sign-extended immediate) for ADDI 0x08, ADDIU 0x09, SLTI 0x0A, SLTIU 0x0B, LW 0x23 and SW 0x2B, and 0 otherwise. ALU operation is: add=0, sub=1, and=2, or=3, xor=4, slt=5, sltu=6, lui=7, chosen from the opcode.
- R8: For R-type in step 2, ALU operation follows the function field: 0x20/0x21→0, 0x22/0x23→1, 0x24→2, 0x25→3, 0x26→4, 0x2A→5, 0x2B→6, any other value→0.
- R9: In step 3, register write is 1 for R-type other than the register jump, for the eight immediate ALU opcodes and for LW. Destination is 1 (rd) for R-type and 0 (rt) otherwise. LW also sets memory read=1 and write-data select=1 (memory). SW sets memory write=1. Memory read and memory write are never both 1.
- R10: For an undefined opcode, register write, memory write and load PC stay 0 in steps 1 to 3. The word equals the one for a defined opcode that never writes anything.
- R11: The function field and the equality flag have no effect for opcodes that do not use them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| regs_equal | input | 1 | 1 when the two source registers hold equal values |
| ctrl_word | output | 17 | Control word for the current step |

## Verification
The step counter is the only register, so the control word is a combinational function of the current step and the inputs. The bench changes the inputs one time unit after a rising edge and compares the word at the following falling edge, within the same cycle. The step count is due one edge after rst_n is sampled high. The bench model advances its own step count on each edge when reset was high at that edge, and returns it to 0 otherwise. As a result, a reset raised in step 2 still expects the step-2 word in that cycle and the fetch word in the next.

// File: rtl/hwc_pkg.sv
// Package: shared encodings for the four-step hardwired control unit.
// Assumes a 6-bit opcode and a 6-bit function field.
package hwc_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    typedef enum logic [1:0] {
        PCS_SEQ = 2'd0,
        PCS_TGT = 2'd1,
        PCS_RSV = 2'd2,
        PCS_ALU = 2'd3
    } pc_src_e;

    typedef enum logic [1:0] {
        ALUB_REG  = 2'd0,
        ALUB_FOUR = 2'd1,
        ALUB_SEXT = 2'd2,
        ALUB_ZEXT = 2'd3
    } alu_b_e;

    typedef enum logic [1:0] {
        DST_RT   = 2'd0,
        DST_RD   = 2'd1,
        DST_LINK = 2'd2,
        DST_RSV  = 2'd3
    } dst_e;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_AND  = 3'd2,
        FN_OR   = 3'd3,
        FN_XOR  = 3'd4,
        FN_SLT  = 3'd5,
        FN_SLTU = 3'd6,
        FN_LUI  = 3'd7
    } alu_fn_e;

    typedef struct packed {
        logic    ld_ir;
        logic    ld_pc;
        logic    ld_gpr;
        logic    mem_rd;
        logic    mem_wr;
        pc_src_e pc_src;
        logic    addr_sel;
        logic    reg_src;
        logic    alu_a;
        alu_b_e  alu_b;
        dst_e    dst_sel;
        alu_fn_e alu_fn;
    } ctrl_word_t;

    localparam int CW_W = $bits(ctrl_word_t);

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_J     = 6'h02;
    localparam logic [OPC_W-1:0] OP_JAL   = 6'h03;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_BNE   = 6'h05;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OP_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OP_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OP_XORI  = 6'h0E;
    localparam logic [OPC_W-1:0] OP_LUI   = 6'h0F;
    localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;

    localparam logic [FN_W-1:0] FC_JR   = 6'h08;
    localparam logic [FN_W-1:0] FC_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FC_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FC_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FC_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FC_AND  = 6'h24;
    localparam logic [FN_W-1:0] FC_OR   = 6'h25;
    localparam logic [FN_W-1:0] FC_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FC_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FC_SLTU = 6'h2B;

    // True for the opcodes the machine implements.
    function automatic logic op_defined(logic [OPC_W-1:0] op);
        case (op)
            OP_RTYPE, OP_J, OP_JAL, OP_BEQ, OP_BNE,
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
            OP_ANDI, OP_ORI, OP_XORI, OP_LUI, OP_LW, OP_SW: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hwc_step_ctr.sv
// Module: wrapping step counter with one-hot step lines.
// Assumes every instruction takes 2**CYC_W steps and reset is synchronous, active low.
module hwc_step_ctr #(
    parameter int CYC_W = 2,
    localparam int NSTEP = 1 << CYC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NSTEP-1:0] step_hot
);

    logic [CYC_W-1:0] step_q;

    // Advance the step each clock; wrap naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_q + 1'b1;
    end

    // One decode line per step value.
    for (genvar s = 0; s < NSTEP; s++) begin : g_step
        assign step_hot[s] = (step_q == CYC_W'(s));
    end

    // R2: the step moves by exactly one while out of reset
    a_r2_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> step_q == $past(step_q) + 1'b1);

    // R1: the first step after reset release is the fetch step
    a_r1_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> step_hot[0]);

    // R2: exactly one step line is active
    a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step_hot) == 1);

endmodule

// File: rtl/hwc_op_decode.sv
// Module: one-of-2**OPC_W opcode decoder.
// Assumes hwc_pkg::op_defined lists the implemented opcodes; undefined codes raise no line.
module hwc_op_decode #(
    parameter int OPC_W = 6,
    localparam int NUM_OPS = 1 << OPC_W
) (
    input  logic [OPC_W-1:0]   opcode,
    output logic [NUM_OPS-1:0] op_hot
);
    import hwc_pkg::*;

    // One line per code, gated by whether that code is implemented.
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_line
        localparam logic [OPC_W-1:0] CODE = OPC_W'(i);
        localparam logic             IMPL = op_defined(CODE);
        assign op_hot[i] = IMPL && (opcode == CODE);
    end

endmodule

// File: rtl/hwc_word_gen.sv
// Module: combinational control-word generator.
// Assumes one-hot step lines and one-hot (or empty) opcode lines.
module hwc_word_gen #(
    parameter int NSTEP   = 4,
    parameter int NUM_OPS = 64,
    parameter int FN_W    = 6
) (
    input  logic                 [NSTEP-1:0]   step_hot,
    input  logic                 [NUM_OPS-1:0] op_hot,
    input  logic                 [FN_W-1:0]    funct,
    input  logic                               regs_equal,
    output hwc_pkg::ctrl_word_t                cw,
    output logic                               op_known
);
    import hwc_pkg::*;

    logic s0, s1, s2, s3;
    logic is_r, is_jr, is_j, is_jal, is_beq, is_bne;
    logic is_alui, is_zext, is_lw, is_sw, take;
    alu_fn_e r_fn, i_fn;

    // Name the step and opcode lines used below.
    always_comb begin
        s0 = step_hot[0];
        s1 = step_hot[1];
        s2 = step_hot[2];
        s3 = step_hot[3];
        is_r    = op_hot[OP_RTYPE];
        is_jr   = is_r && (funct == FC_JR);
        is_j    = op_hot[OP_J];
        is_jal  = op_hot[OP_JAL];
        is_beq  = op_hot[OP_BEQ];
        is_bne  = op_hot[OP_BNE];
        is_zext = op_hot[OP_ANDI] | op_hot[OP_ORI] | op_hot[OP_XORI] | op_hot[OP_LUI];
        is_alui = is_zext | op_hot[OP_ADDI] | op_hot[OP_ADDIU]
                | op_hot[OP_SLTI] | op_hot[OP_SLTIU];
        is_lw   = op_hot[OP_LW];
        is_sw   = op_hot[OP_SW];
        take    = (is_beq & regs_equal) | (is_bne & ~regs_equal);
        op_known = |op_hot;
    end

    // ALU operation for R-type, chosen by the function field.
    always_comb begin
        case (funct)
            FC_SUB, FC_SUBU: r_fn = FN_SUB;
            FC_AND:          r_fn = FN_AND;
            FC_OR:           r_fn = FN_OR;
            FC_XOR:          r_fn = FN_XOR;
            FC_SLT:          r_fn = FN_SLT;
            FC_SLTU:         r_fn = FN_SLTU;
            default:         r_fn = FN_ADD;
        endcase
    end

    // ALU operation for immediate opcodes.
    always_comb begin
        i_fn = FN_ADD;
        if (op_hot[OP_SLTI])  i_fn = FN_SLT;
        if (op_hot[OP_SLTIU]) i_fn = FN_SLTU;
        if (op_hot[OP_ANDI])  i_fn = FN_AND;
        if (op_hot[OP_ORI])   i_fn = FN_OR;
        if (op_hot[OP_XORI])  i_fn = FN_XOR;
        if (op_hot[OP_LUI])   i_fn = FN_LUI;
    end

    // Assemble each field from the step and opcode terms.
    always_comb begin
        cw = '0;
        cw.ld_ir    = s0;
        cw.ld_pc    = s0 | (s1 & (is_j | is_jal | is_jr | take));
        cw.ld_gpr   = (s1 & is_jal) | (s3 & ((is_r & ~is_jr) | is_alui | is_lw));
        cw.mem_rd   = s0 | (s3 & is_lw);
        cw.mem_wr   = s3 & is_sw;
        cw.pc_src   = s1 ? PCS_TGT : (s3 ? PCS_ALU : PCS_SEQ);
        cw.addr_sel = ~s0;
        cw.reg_src  = s3 & is_lw;
        cw.alu_a    = ~s0;
        if (s0)
            cw.alu_b = ALUB_FOUR;
        else if (s2 & is_zext)
            cw.alu_b = ALUB_ZEXT;
        else if (s2 & (is_alui | is_lw | is_sw))
            cw.alu_b = ALUB_SEXT;
        else
            cw.alu_b = ALUB_REG;
        if (s1 & is_jal)
            cw.dst_sel = DST_LINK;
        else if (s3 & is_r)
            cw.dst_sel = DST_RD;
        else
            cw.dst_sel = DST_RT;
        if (s1)
            cw.alu_fn = FN_SUB;
        else if (s2 & is_r)
            cw.alu_fn = r_fn;
        else if (s2)
            cw.alu_fn = i_fn;
        else
            cw.alu_fn = FN_ADD;
    end

endmodule

// File: rtl/hwc_ctrl_unit.sv
// Module: top of the hardwired four-step control unit.
// Assumes opcode/funct come from the instruction register and regs_equal from the register file.
module hwc_ctrl_unit #(
    parameter int CYC_W = 2,
    parameter int OPC_W = 6,
    parameter int FN_W  = 6,
    localparam int NSTEP   = 1 << CYC_W,
    localparam int NUM_OPS = 1 << OPC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [OPC_W-1:0]        opcode,
    input  logic [FN_W-1:0]         funct,
    input  logic                    regs_equal,
    output logic [hwc_pkg::CW_W-1:0] ctrl_word
);
    import hwc_pkg::*;

    logic [NSTEP-1:0]   step_hot;
    logic [NUM_OPS-1:0] op_hot;
    logic               op_known;
    ctrl_word_t         cw;

    hwc_step_ctr #(.CYC_W(CYC_W)) i_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_hot (step_hot)
    );

    hwc_op_decode #(.OPC_W(OPC_W)) i_dec (
        .opcode (opcode),
        .op_hot (op_hot)
    );

    hwc_word_gen #(.NSTEP(NSTEP), .NUM_OPS(NUM_OPS), .FN_W(FN_W)) i_gen (
        .step_hot   (step_hot),
        .op_hot     (op_hot),
        .funct      (funct),
        .regs_equal (regs_equal),
        .cw         (cw),
        .op_known   (op_known)
    );

    assign ctrl_word = cw;

    // R3: instruction register loads only in the fetch step
    a_r3_ir_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
        cw.ld_ir |-> step_hot[0]);

    // R4: PC loads only in steps 0 and 1
    a_r4_pc_window: assert property (@(posedge clk) disable iff (!rst_n)
        cw.ld_pc |-> (step_hot[0] | step_hot[1]));

    // R10: undefined opcode leaves architectural state alone after fetch
    a_r10_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_known && !step_hot[0]) |-> !(cw.ld_gpr | cw.mem_wr | cw.ld_pc));

    // R9: memory is never read and written together
    a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw.mem_rd && cw.mem_wr));

endmodule

// File: tb/test_hwc_ctrl_unit.sv
module test_hwc_ctrl_unit;

    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic        regs_equal;
    logic [16:0] ctrl_word;

    int compared = 0;
    int mismatched = 0;
    int step_m = 0;
    bit done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];
    logic [16:0] got_exp;
    string       got_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwc_ctrl_unit i_hwc_ctrl_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .funct      (funct),
        .regs_equal (regs_equal),
        .ctrl_word  (ctrl_word)
    );

    // Expected word from the requirement tables.
    function automatic logic [16:0] model(int s, logic [5:0] op, logic [5:0] fn, logic eq);
        logic ir, pc, wr, mr, mw, asel, rsrc, aa;
        logic [1:0] psrc, bsel, dst;
        logic [2:0] alu;
        bit rt, imm_z, imm_s, jr;
        rt    = (op == 6'h00);
        jr    = rt && (fn == 6'h08);
        imm_z = (op inside {6'h0C, 6'h0D, 6'h0E, 6'h0F});
        imm_s = (op inside {6'h08, 6'h09, 6'h0A, 6'h0B, 6'h23, 6'h2B});
        ir = (s == 0);
        pc = 0; wr = 0; mr = 0; mw = 0; rsrc = 0; dst = 0; alu = 0; bsel = 0;
        asel = (s != 0); aa = (s != 0);
        psrc = (s == 1) ? 2'd1 : ((s == 3) ? 2'd3 : 2'd0);
        case (s)
            0: begin pc = 1; mr = 1; bsel = 2'd1; end
            1: begin
                alu = 3'd1;
                if (op == 6'h02 || op == 6'h03 || jr) pc = 1;
                if (op == 6'h04 && eq)  pc = 1;
                if (op == 6'h05 && !eq) pc = 1;
                if (op == 6'h03) begin wr = 1; dst = 2'd2; end
            end
            2: begin
                if (imm_z) bsel = 2'd3;
                else if (imm_s) bsel = 2'd2;
                if (rt) begin
                    case (fn)
                        6'h22, 6'h23: alu = 3'd1;
                        6'h24: alu = 3'd2;
                        6'h25: alu = 3'd3;
                        6'h26: alu = 3'd4;
                        6'h2A: alu = 3'd5;
                        6'h2B: alu = 3'd6;
                        default: alu = 3'd0;
                    endcase
                end else begin
                    case (op)
                        6'h0A: alu = 3'd5;
                        6'h0B: alu = 3'd6;
                        6'h0C: alu = 3'd2;
                        6'h0D: alu = 3'd3;
                        6'h0E: alu = 3'd4;
                        6'h0F: alu = 3'd7;
                        default: alu = 3'd0;
                    endcase
                end
            end
            default: begin
                if (rt) dst = 2'd1;
                if ((rt && !jr) || (imm_z || (imm_s && op != 6'h23 && op != 6'h2B)))
                    wr = 1;
                if (op == 6'h23) begin wr = 1; mr = 1; rsrc = 1; end
                if (op == 6'h2B) mw = 1;
            end
        endcase
        return {ir, pc, wr, mr, mw, psrc, asel, rsrc, aa, bsel, dst, alu};
    endfunction

    // Driver: apply inputs for one cycle and queue the expected word.
    task automatic step(logic [5:0] op, logic [5:0] fn, logic eq, string tag);
        opcode = op; funct = fn; regs_equal = eq;
        exp_q.push_back(model(step_m, op, fn, eq));
        tag_q.push_back($sformatf("%s step%0d op%02h fn%02h eq%0d", tag, step_m, op, fn, eq));
        @(posedge clk);
        #1;
        step_m = rst_n ? (step_m + 1) % 4 : 0;
    endtask

    task automatic instr(logic [5:0] op, logic [5:0] fn, logic eq, string tag);
        for (int k = 0; k < 4; k++) step(op, fn, eq, tag);
    endtask

    // Monitor: compare mid-cycle against the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            got_exp = exp_q.pop_front();
            got_tag = tag_q.pop_front();
            compared++;
            if (ctrl_word !== got_exp) begin
                mismatched++;
                $display("FAIL %s: actual %05h expected %05h", got_tag, ctrl_word, got_exp);
            end
        end
    end

    initial begin
        rst_n = 1'b0; opcode = 6'h00; funct = 6'h20; regs_equal = 1'b0;
        @(posedge clk);
        #1;
        step(6'h2B, 6'h3F, 1'b1, "R1 reset");   // reset holds the fetch word, R3
        step(6'h00, 6'h20, 1'b0, "R1 reset");
        rst_n = 1'b1;
        instr(6'h00, 6'h20, 1'b0, "R8 add");
        instr(6'h00, 6'h23, 1'b1, "R8 subu");
        instr(6'h00, 6'h24, 1'b0, "R8 and");
        instr(6'h00, 6'h25, 1'b0, "R8 or");
        instr(6'h00, 6'h26, 1'b0, "R8 xor");
        instr(6'h00, 6'h2A, 1'b0, "R8 slt");
        instr(6'h00, 6'h2B, 1'b0, "R8 sltu");
        instr(6'h00, 6'h3F, 1'b0, "R8 other funct");
        instr(6'h00, 6'h08, 1'b0, "R4 register jump");
        instr(6'h02, 6'h08, 1'b1, "R2 R11 jump four steps");
        instr(6'h03, 6'h00, 1'b0, "R6 jal link");
        instr(6'h04, 6'h20, 1'b1, "R4 beq taken");
        instr(6'h04, 6'h20, 1'b0, "R4 beq not taken");
        instr(6'h05, 6'h00, 1'b0, "R4 bne taken");
        instr(6'h05, 6'h00, 1'b1, "R4 bne not taken");
        instr(6'h08, 6'h22, 1'b1, "R7 R11 addi");
        instr(6'h09, 6'h00, 1'b0, "R7 addiu");
        instr(6'h0A, 6'h00, 1'b0, "R7 slti");
        instr(6'h0B, 6'h00, 1'b0, "R7 sltiu");
        instr(6'h0C, 6'h2A, 1'b0, "R7 R11 andi");
        instr(6'h0D, 6'h00, 1'b0, "R7 ori");
        instr(6'h0E, 6'h00, 1'b0, "R7 xori");
        instr(6'h0F, 6'h00, 1'b0, "R7 lui");
        instr(6'h23, 6'h00, 1'b0, "R9 lw");
        instr(6'h2B, 6'h08, 1'b1, "R9 sw");
        instr(6'h01, 6'h08, 1'b1, "R10 undefined 01");
        instr(6'h10, 6'h20, 1'b0, "R10 undefined 10");
        instr(6'h3F, 6'h00, 1'b0, "R10 undefined 3F");
        instr(6'h06, 6'h00, 1'b1, "R10 undefined 06");
        // R1: reset in mid-instruction
        step(6'h23, 6'h00, 1'b0, "R5 lw");
        step(6'h23, 6'h00, 1'b0, "R5 lw");
        rst_n = 1'b0;
        step(6'h23, 6'h00, 1'b0, "R1 before reset edge");
        step(6'h23, 6'h00, 1'b0, "R1 after reset edge");
        rst_n = 1'b1;
        instr(6'h2B, 6'h00, 1'b0, "R2 R5 sw after reset");
        instr(6'h04, 6'h00, 1'b1, "R5 beq");
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R2 progress: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule